// File: doc/BRIEF.md
# Interleaved ADC Output Formatter

This block sits behind a bank of time-interleaved converter slices. Every clock cycle a phase index names the slice whose turn it is. The block picks that slice's 11-bit raw result and its valid strobe, and turns the result into a 10-bit straight-binary word plus an overrange flag. The word then passes through a fixed-depth alignment pipe. Every word therefore leaves the block the same number of cycles after it was selected, whichever slice produced it.

The final stage registers the word on the rising clock edge. It raises a one-cycle data-valid pulse for each word it loads, and otherwise holds the last word. An active-high disable input puts the ten data lines and the overrange line into high impedance. The data-valid pulse keeps running while the bus is disabled. Reset is synchronous and active high.

Top module: `ifmt_output_formatter`

## Requirements
- R1: In each cycle only the slice named by `phase` (slot i occupies bits [11*i+10 : 11*i] of `slice_raw`, strobe bit i of `slice_vld`) contributes. The results and strobes of all other slices have no effect on the outputs.
- R2: A selected raw value below 1024 appears unchanged on `data_out` as straight binary (0 gives all zeros, 1023 gives all ones), with `over_out` low.
- R3: A selected raw value of 1024 or more (bit 10 set) drives `over_out` high and forces `data_out` to 10'h3FF.
- R4: A result selected with its strobe high in cycle n appears on the outputs in cycle n+12, and `dav` is high in exactly that cycle.
- R5: A cycle whose selected strobe is low produces no word. Twelve cycles later `dav` is low and the outputs keep the previous word.
- R6: After reset, `dav` is low and `data_out`/`over_out` read zero until the first accepted word arrives.
- R7: While `out_disable` is high, `data_out` and `over_out` are high impedance. The held word is not disturbed and reappears when `out_disable` returns low.
- R8: `dav` is never tri-stated and does not depend on `out_disable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| slice_raw | input | 176 | Sixteen packed 11-bit slice results, slot 0 in the low bits |
| slice_vld | input | 16 | Per-slice result-valid strobes |
| phase | input | 4 | Index of the slice sampled this cycle |
| out_disable | input | 1 | High places data and overrange lines in high impedance |
| data_out | output | 10 | Straight-binary output word |
| over_out | output | 1 | Overrange flag |
| dav | output | 1 | One-cycle pulse per registered output word |

## Verification
A wrong phase decode shows up as a word coming from a neighbouring slice. The bench fills the other slots with values unrelated to the selected one, so the wrong word is visible on the very word that was due. A missing or extra stage in the alignment pipe moves every `dav` pulse by a cycle, and the first accepted word already shows it. A bad saturation rule or a hold path that leaks through on idle cycles corrupts `data_out` within twelve cycles of the offending input. The bench sweeps every 11-bit raw value against an arithmetic model and also steps the phase out of order.

// File: rtl/ifmt_pkg.sv
`timescale 1ns/1ps
package ifmt_pkg;
    localparam int CODE_W = 10;
    localparam int RAW_W  = CODE_W + 1;

    typedef struct packed {
        logic              vld;
        logic              ovr;
        logic [CODE_W-1:0] code;
    } ifmt_word_t;

    // Straight binary pass-through; the top raw bit marks overrange and saturates the code.
    function automatic ifmt_word_t ifmt_format(input logic vld, input logic [RAW_W-1:0] raw);
        ifmt_word_t w;
        w.vld  = vld;
        w.ovr  = raw[RAW_W-1];
        w.code = raw[RAW_W-1] ? {CODE_W{1'b1}} : raw[CODE_W-1:0];
        return w;
    endfunction
endpackage

// File: rtl/ifmt_slice_sel.sv
`timescale 1ns/1ps
module ifmt_slice_sel
    import ifmt_pkg::*;
#(
    parameter int N_SLICE = 16,
    parameter int PH_W    = 4
) (
    input  logic [N_SLICE*RAW_W-1:0] slice_raw,
    input  logic [N_SLICE-1:0]       slice_vld,
    input  logic [PH_W-1:0]          phase,
    output ifmt_word_t               sel_word
);
    logic [RAW_W-1:0] raw_arr [N_SLICE];

    for (genvar i = 0; i < N_SLICE; i++) begin : g_unpack
        assign raw_arr[i] = slice_raw[i*RAW_W +: RAW_W];
    end

    always_comb begin
        if (int'(phase) < N_SLICE)
            sel_word = ifmt_format(slice_vld[phase], raw_arr[phase]);
        else
            sel_word = '0;
    end
endmodule

// File: rtl/ifmt_align.sv
`timescale 1ns/1ps
module ifmt_align
    import ifmt_pkg::*;
#(
    parameter int DEPTH = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  ifmt_word_t din,
    output ifmt_word_t dout
);
    if (DEPTH == 0) begin : g_pass
        assign dout = din;
    end else begin : g_pipe
        ifmt_word_t stg [DEPTH];
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stg[s] <= '0;
                else if (s == 0)
                    stg[s] <= din;
                else
                    stg[s] <= stg[s-1];
            end
        end
        assign dout = stg[DEPTH-1];
    end
endmodule

// File: rtl/ifmt_out_stage.sv
`timescale 1ns/1ps
module ifmt_out_stage
    import ifmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ifmt_word_t        din,
    output logic [CODE_W-1:0] q_code,
    output logic              q_ovr,
    output logic              q_dav
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_code <= '0;
            q_ovr  <= 1'b0;
            q_dav  <= 1'b0;
        end else begin
            q_dav <= din.vld;
            if (din.vld) begin
                q_code <= din.code;
                q_ovr  <= din.ovr;
            end
        end
    end
endmodule

// File: rtl/ifmt_output_formatter.sv
`timescale 1ns/1ps
module ifmt_output_formatter
    import ifmt_pkg::*;
#(
    parameter int N_SLICE = 16,
    parameter int LAT     = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_SLICE*RAW_W-1:0]   slice_raw,
    input  logic [N_SLICE-1:0]         slice_vld,
    input  logic [$clog2(N_SLICE)-1:0] phase,
    input  logic                       out_disable,
    output wire  [CODE_W-1:0]          data_out,
    output wire                        over_out,
    output logic                       dav
);
    localparam int PH_W        = $clog2(N_SLICE);
    localparam int ALIGN_DEPTH = (LAT > 1) ? LAT - 1 : 0;

    ifmt_word_t        sel_word;
    ifmt_word_t        line_word;
    logic [CODE_W-1:0] q_code;
    logic              q_ovr;

    ifmt_slice_sel #(.N_SLICE(N_SLICE), .PH_W(PH_W)) u_sel (
        .slice_raw (slice_raw),
        .slice_vld (slice_vld),
        .phase     (phase),
        .sel_word  (sel_word)
    );

    ifmt_align #(.DEPTH(ALIGN_DEPTH)) u_align (
        .clk  (clk),
        .rst  (rst),
        .din  (sel_word),
        .dout (line_word)
    );

    ifmt_out_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .din    (line_word),
        .q_code (q_code),
        .q_ovr  (q_ovr),
        .q_dav  (dav)
    );

    assign data_out = out_disable ? {CODE_W{1'bz}} : q_code;
    assign over_out = out_disable ? 1'bz : q_ovr;
endmodule

// File: rtl/ifmt_output_formatter_chk.sv
`timescale 1ns/1ps
module ifmt_output_formatter_chk
    import ifmt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              out_disable,
    input logic [CODE_W-1:0] data_out,
    input logic              over_out,
    input logic              dav,
    input logic              line_vld,
    input logic [CODE_W-1:0] q_code
);
    assert_ovr_saturates_R3: assert property (@(posedge clk) disable iff (rst)
        (!out_disable && over_out) |-> (data_out == {CODE_W{1'b1}}));

    assert_dav_follows_line_R4: assert property (@(posedge clk) disable iff (rst)
        line_vld |=> dav);

    assert_no_word_no_dav_R5: assert property (@(posedge clk) disable iff (rst)
        !line_vld |=> !dav);

    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !dav |-> $stable(q_code));

    assert_reset_clears_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dav && q_code == '0));
endmodule

bind ifmt_output_formatter ifmt_output_formatter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .out_disable (out_disable),
    .data_out    (data_out),
    .over_out    (over_out),
    .dav         (dav),
    .line_vld    (line_word.vld),
    .q_code      (q_code)
);

// File: tb/tb_ifmt_output_formatter.sv
`timescale 1ns/1ps
module tb_ifmt_output_formatter;
    localparam int NS    = 16;
    localparam int RW    = 11;
    localparam int CW    = 10;
    localparam int LAT   = 12;
    localparam int N_CYC = 2300;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NS*RW-1:0] slice_raw = '0;
    logic [NS-1:0]  slice_vld = '0;
    logic [3:0]     phase = '0;
    logic           out_disable = 1'b0;
    wire  [CW-1:0]  data_out;
    wire            over_out;
    logic           dav;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic          exp_v [N_CYC];
    logic [CW-1:0] exp_c [N_CYC];
    logic          exp_o [N_CYC];
    logic [CW-1:0] held_c = '0;
    logic          held_o = 1'b0;
    logic          cur_dis = 1'b0;
    logic          seen_word = 1'b0;

    always #2 clk = ~clk;

    ifmt_output_formatter #(.N_SLICE(NS), .LAT(LAT)) dut (
        .clk(clk), .rst(rst), .slice_raw(slice_raw), .slice_vld(slice_vld),
        .phase(phase), .out_disable(out_disable),
        .data_out(data_out), .over_out(over_out), .dav(dav)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
        end
    endtask

    task automatic check_cycle(input int m);
        logic edav;
        edav = 1'b0;
        if (m >= LAT) begin
            edav = exp_v[m-LAT];
            if (edav) begin
                held_c = exp_c[m-LAT];
                held_o = exp_o[m-LAT];
                seen_word = 1'b1;
            end
        end
        // R8: dav runs regardless of the disable input
        check(dav == edav, cur_dis ? "R8 dav while disabled" : "R4 R5 dav timing", dav, edav);
        if (cur_dis) begin
            // R7: bus released (reads z in four-state, 0 in two-state)
            check((data_out === {CW{1'bz}}) || (data_out === {CW{1'b0}}) || (held_c == '0),
                  "R7 data not released", data_out, 0);
        end else if (!seen_word) begin
            check(data_out == '0 && over_out == 1'b0, "R6 output before first word",
                  {over_out, data_out}, 0);
        end else begin
            check(data_out == held_c && over_out == held_o,
                  held_o ? "R3 R1 saturated word" : "R2 R1 straight binary word",
                  {over_out, data_out}, {held_o, held_c});
        end
    endtask

    task automatic drive_cycle(input int n);
        logic [RW-1:0] v;
        int ph;
        logic rst_v, sv, dis;
        v     = RW'(n * 1);
        rst_v = (n < 4);
        if (n >= 4) v = RW'(n - 4);
        if (n - 4 >= 2048) v = RW'((n * 37 + 5) % 2048);
        ph    = (n < 1200) ? (n % NS) : ((n * 7 + 3) % NS);
        sv    = (n % 7 != 3);
        dis   = ((n / 64) % 5 == 2);
        for (int i = 0; i < NS; i++) begin
            slice_raw[i*RW +: RW] = RW'(~v) ^ RW'(i * 93);
            slice_vld[i] = ((n + i) % 3 == 0);
        end
        slice_raw[ph*RW +: RW] = v;
        slice_vld[ph] = sv;
        phase       = 4'(ph);
        rst         = rst_v;
        out_disable = dis;
        cur_dis     = dis;
        exp_v[n] = !rst_v && sv;
        exp_o[n] = v[RW-1];
        exp_c[n] = v[RW-1] ? {CW{1'b1}} : v[CW-1:0];
    endtask

    initial begin
        for (int n = 0; n < N_CYC; n++) begin
            @(negedge clk);
            if (done) break;
            if (n > 0) check_cycle(n);
            else check(dav == 1'b0 && data_out == '0, "R6 reset state", {dav, data_out}, 0);
            drive_cycle(n);
        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule